// File: doc/BRIEF.md
# Receive Byte-to-Word Packer with Leftover Report

This block sits between the receive side of a SCSI data phase and a 32-bit DMA write port. Bytes arrive one per handshake. The block packs them big-endian into whole memory words and issues a word write each time a word is complete. When the transfer ends, the bytes that never filled a whole word stay visible to software. They are exposed through two 16-bit holding registers together with a count of how many bytes are valid.

A transfer starts with a command pulse that carries a byte start address and a byte length. An odd start address is refused and no data moves. If address bit 1 is set, the transfer starts in half-word-offset mode and the first word written carries only its lower two bytes. A down counter loaded with the length shows the residual, which is the length minus the bytes taken. A transfer ends when that counter reaches zero or when a byte marked as final is accepted. A clear input wipes the packing state at any time.

Top module: `rx_word_packer`

## Requirements
- R1: A start command whose address has bit 0 set raises `addr_err`, leaves `busy` low, keeps `in_ready` low, loads nothing into the residual and produces no word write.
- R2: A start with address bit 1 set raises `half_mode`. After two bytes, the first word is written with `wr_be` = 4'b0011. Its bytes sit in `wr_data[15:8]` and then `wr_data[7:0]`, and its upper half is zero.
- R3: The first byte of a word goes to `wr_data[31:24]`, and each following byte goes to the next lower byte. A full word is written with `wr_be` = 4'b1111 (bit 3 marks bits 31:24) one cycle after its last byte is accepted. Word addresses start at the start address with bits 1:0 cleared and step by 4.
- R4: `residual` loads the length on a valid start and drops by one for every accepted byte. At the end it shows the length minus the bytes taken.
- R5: The transfer ends when the byte that brings `residual` to zero, or a byte with `in_last` high, is accepted. On that edge `busy` falls and `done` rises.
- R6: At the end, `leftover` gives the number of bytes (0 to 3) not written as a word. They fill `hold_hi[15:8]`, then `hold_hi[7:0]`, then `hold_lo[15:8]`, and the unused fields read zero.
- R7: In half-word-offset mode, a single byte left in the first word gives `leftover` = 1 with the byte in `hold_lo[15:8]`.
- R8: `pack_clr` clears `residual`, both holding registers, `half_mode`, `leftover`, `done`, `addr_err` and `busy` on the next edge.
- R9: A start command that arrives while `busy` is high is ignored, and the transfer in progress continues unchanged.
- R10: A start with length zero gives `done` high and `busy` low on the next edge, with no word write.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pack_clr | input | 1 | Clears packing state, counter and flags |
| cmd_go | input | 1 | Start pulse, taken when idle |
| cmd_addr | input | ADDR_W | Byte start address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte (early end) |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| wr_en | output | 1 | Word write strobe |
| wr_addr | output | ADDR_W | Word byte address, bits 1:0 zero |
| wr_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| wr_data | output | 32 | Packed big-endian word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| addr_err | output | 1 | Odd start address refused |
| half_mode | output | 1 | Half-word-offset start |
| leftover | output | 2 | Unwritten byte count at end |
| hold_hi | output | 16 | Upper holding half |
| hold_lo | output | 16 | Lower holding half |
| residual | output | LEN_W | Length minus bytes taken |

## Verification
The bench builds the block with ADDR_W = 16 and LEN_W = 8. With an 8-bit length, a 255-byte transfer uses the full counter range, so the largest residual and a long run of word address steps can be checked within a short run. The 16-bit address keeps the word addresses in the scoreboard compact. The bench also covers every leftover count in both start modes, early end by `in_last`, and a clear issued mid-transfer.

// File: rtl/wp_pkg.sv
// Shared constants for the receive word packer.
package wp_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int HALF_W = WORD_W / 2;
    typedef logic [$clog2(LANES)-1:0] lane_t;
endpackage

// File: rtl/wp_residual.sv
// Residual byte counter: loads the transfer length, counts down one per
// accepted byte. Assumes load and dec are never high together.
module wp_residual #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic [LEN_W-1:0] residual
);
    // Counter register with clear, load and decrement.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            residual <= '0;
        else if (load)
            residual <= load_val;
        else if (dec)
            residual <= residual - 1'b1;
    end

    // R4
    res_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec && !load && !clr |=> residual == LEN_W'($past(residual) - 1'b1));
endmodule

// File: rtl/wp_hold.sv
// Byte-lane holding store. Lane 0 is the most significant byte of the word.
// Supplies the word with the incoming byte merged in, for the write path.
module wp_hold
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr,
    input  lane_t             lane,
    input  logic [BYTE_W-1:0] din,
    output logic [HALF_W-1:0] hold_hi,
    output logic [HALF_W-1:0] hold_lo,
    output logic [WORD_W-1:0] word_next
);
    logic [BYTE_W-1:0] lane_q   [LANES];
    logic [BYTE_W-1:0] lane_nxt [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane register, written when its lane is selected.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                lane_q[g] <= '0;
            else if (wr && lane == lane_t'(g))
                lane_q[g] <= din;
        end
        // Merge view of this lane for the word about to be written.
        assign lane_nxt[g] = (wr && lane == lane_t'(g)) ? din : lane_q[g];
        assign word_next[WORD_W-1-g*BYTE_W -: BYTE_W] = lane_nxt[g];
    end

    assign hold_hi = {lane_q[0], lane_q[1]};
    assign hold_lo = {lane_q[2], lane_q[3]};

    // R8
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> hold_hi == '0 && hold_lo == '0);
endmodule

// File: rtl/wp_ctrl.sv
// Transfer sequencer: accepts starts, tracks the byte lane and word address,
// issues word writes and records end status. Assumes residual and holding
// state live outside and follow the load/take/clear strobes given here.
module wp_ctrl
    import wp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_clr,
    input  logic              cmd_go,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_len_zero,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic              res_one,
    input  logic [WORD_W-1:0] word_next,
    output logic              start_ok,
    output logic              take,
    output logic              emit,
    output lane_t             lane,
    output logic              busy,
    output logic              done,
    output logic              addr_err,
    output logic              half_mode,
    output logic [1:0]        leftover,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] wr_data
);
    logic              first_q;
    logic [ADDR_W-1:0] waddr_q;
    logic              last;
    logic              bad_go;

    assign take     = busy && in_valid;
    assign start_ok = cmd_go && !busy && !cmd_addr[0] && !pack_clr;
    assign bad_go   = cmd_go && !busy && cmd_addr[0];
    assign emit     = take && (lane == lane_t'(LANES-1));
    assign last     = take && (res_one || in_last);

    // Sequencer state: start, lane advance, word write and end status.
    always_ff @(posedge clk) begin
        if (!rst_n || pack_clr) begin
            busy <= 1'b0; done <= 1'b0; addr_err <= 1'b0; half_mode <= 1'b0;
            leftover <= '0; first_q <= 1'b0; lane <= '0; waddr_q <= '0;
            wr_en <= 1'b0; wr_addr <= '0; wr_be <= '0; wr_data <= '0;
        end else begin
            wr_en <= emit;
            if (emit) begin
                wr_data <= word_next;
                wr_addr <= waddr_q;
                wr_be   <= (first_q && half_mode) ? 4'b0011 : 4'b1111;
                waddr_q <= waddr_q + ADDR_W'(LANES);
                lane    <= '0;
                first_q <= 1'b0;
            end else if (take) begin
                lane <= lane + 1'b1;
            end
            if (start_ok) begin
                addr_err  <= 1'b0;
                half_mode <= cmd_addr[1];
                first_q   <= 1'b1;
                lane      <= {cmd_addr[1], 1'b0};
                waddr_q   <= {cmd_addr[ADDR_W-1:2], 2'b00};
                leftover  <= '0;
                done      <= cmd_len_zero;
                busy      <= !cmd_len_zero;
            end else if (bad_go) begin
                addr_err <= 1'b1;
                done     <= 1'b0;
            end
            if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
                if (emit)
                    leftover <= '0;
                else if (first_q && half_mode)
                    leftover <= 2'(lane - 1'b1);
                else
                    leftover <= 2'(lane + 1'b1);
            end
        end
    end

    // R1
    odd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_go && !pack_clr |=> addr_err && !busy);
    // R5
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last && !pack_clr |=> done && !busy);
    // R6
    full_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && done |-> leftover == 2'd0);
    // R2
    half_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_be == 4'b0011 |-> half_mode && wr_data[WORD_W-1:HALF_W] == '0);
endmodule

// File: rtl/rx_word_packer.sv
// Top of the receive word packer: joins the sequencer, the residual counter
// and the byte-lane holding store. Assumes one byte per accepted handshake.
module rx_word_packer
    import wp_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pack_clr,
    input  logic              cmd_go,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [3:0]        wr_be,
    output logic [31:0]       wr_data,
    output logic              busy,
    output logic              done,
    output logic              addr_err,
    output logic              half_mode,
    output logic [1:0]        leftover,
    output logic [15:0]       hold_hi,
    output logic [15:0]       hold_lo,
    output logic [LEN_W-1:0]  residual
);
    logic              start_ok, take, emit;
    lane_t             lane;
    logic [WORD_W-1:0] word_next;

    assign in_ready = busy;

    wp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pack_clr(pack_clr), .cmd_go(cmd_go),
        .cmd_addr(cmd_addr), .cmd_len_zero(cmd_len == '0), .in_valid(in_valid),
        .in_last(in_last), .res_one(residual == LEN_W'(1)), .word_next(word_next),
        .start_ok(start_ok), .take(take), .emit(emit), .lane(lane),
        .busy(busy), .done(done), .addr_err(addr_err), .half_mode(half_mode),
        .leftover(leftover), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(wr_data)
    );

    wp_residual #(.LEN_W(LEN_W)) u_res (
        .clk(clk), .rst_n(rst_n), .clr(pack_clr), .load(start_ok),
        .load_val(cmd_len), .dec(take), .residual(residual)
    );

    wp_hold u_hold (
        .clk(clk), .rst_n(rst_n), .clr(pack_clr || start_ok || emit),
        .wr(take), .lane(lane), .din(in_data),
        .hold_hi(hold_hi), .hold_lo(hold_lo), .word_next(word_next)
    );

    // R9
    busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_go && !in_valid && !pack_clr |=> busy && $stable(residual));
endmodule

// File: tb/rx_word_packer_test.sv
`timescale 1ns/1ps
module rx_word_packer_test;
    localparam int AW = 16;
    localparam int LW = 8;

    logic clk = 1'b0, rst_n = 1'b0, pack_clr = 1'b0, cmd_go = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready, wr_en, busy, done, addr_err, half_mode;
    logic [AW-1:0] wr_addr;
    logic [3:0] wr_be;
    logic [31:0] wr_data;
    logic [1:0] leftover;
    logic [15:0] hold_hi, hold_lo;
    logic [LW-1:0] residual;

    int checks = 0, errors = 0;
    logic [AW+4+32-1:0] exp_q[$];

    always #4 clk = ~clk;

    rx_word_packer #(.ADDR_W(AW), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .pack_clr(pack_clr), .cmd_go(cmd_go),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .busy(busy), .done(done), .addr_err(addr_err), .half_mode(half_mode),
        .leftover(leftover), .hold_hi(hold_hi), .hold_lo(hold_lo),
        .residual(residual)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every word write is compared with the next expected item (R3, R2).
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", {wr_addr, wr_be, wr_data}, 0);
            else begin
                logic [AW+4+32-1:0] e;
                e = exp_q.pop_front();
                chk({wr_addr, wr_be, wr_data} == e, "R3 word write", {wr_addr, wr_be, wr_data}, e);
            end
        end
    end

    // Driver and model: runs one transfer and pushes the expected words.
    task automatic xfer(input logic [AW-1:0] a, input int len, input int last_at,
                        input logic [7:0] seed, input bit gap, input bit poke, input int clr_at);
        int pos, cnt, taken;
        bit first, half;
        logic [AW-1:0] wa;
        logic [31:0] w;
        logic [LW-1:0] prev_res;
        prev_res = residual;
        @(negedge clk);
        cmd_go = 1'b1; cmd_addr = a; cmd_len = LW'(len);
        @(negedge clk);
        cmd_go = 1'b0;
        if (a[0]) begin
            #1;
            chk(addr_err == 1'b1, "R1 addr_err", addr_err, 1);
            chk(busy == 1'b0 && in_ready == 1'b0, "R1 idle", {busy, in_ready}, 0);
            chk(residual == prev_res, "R1 residual kept", residual, prev_res);
            repeat (4) @(negedge clk);
            chk(exp_q.size() == 0 && wr_en == 1'b0, "R1 no write", wr_en, 0);
            return;
        end
        half = a[1]; first = 1'b1; pos = half ? 2 : 0; cnt = 0;
        wa = a & ~AW'(3); w = '0; taken = 0;
        #1 chk(half_mode == half, "R2 half_mode flag", half_mode, half);
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            if (i == clr_at) begin
                in_valid = 1'b0; pack_clr = 1'b1;
                @(negedge clk);
                pack_clr = 1'b0;
                #1;
                chk(residual == 0 && hold_hi == 0 && hold_lo == 0, "R8 counter and holds",
                    {residual, hold_hi, hold_lo}, 0);
                chk(half_mode == 0 && leftover == 0 && done == 0 && busy == 0 && addr_err == 0,
                    "R8 flags", {half_mode, leftover, done, busy, addr_err}, 0);
                return;
            end
            if (gap && (i % 3 == 1)) begin
                in_valid = 1'b0; in_data = 8'hEE; cmd_go = 1'b0;
                @(negedge clk);
            end
            d = seed + 8'(i);
            in_valid = 1'b1; in_data = d; in_last = (i == last_at);
            cmd_go = poke && (i == 2);
            cmd_addr = poke && (i == 2) ? AW'(1) : a;
            cmd_len = poke && (i == 2) ? LW'(99) : LW'(len);
            w[31-8*pos -: 8] = d; cnt++; taken++;
            if (pos == 3) begin
                exp_q.push_back({wa, (first && half) ? 4'b0011 : 4'b1111, w});
                wa += AW'(4); w = '0; pos = 0; cnt = 0; first = 1'b0;
            end else pos++;
            @(negedge clk);
            cmd_go = 1'b0;
            if (i == last_at) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
        if (len == 0) begin
            #1;
            chk(done == 1'b1 && busy == 1'b0, "R10 zero length done", {done, busy}, 2);
        end
        @(negedge clk);
        #1;
        chk(done == 1'b1, "R5 done", done, 1);
        chk(busy == 1'b0, "R5 busy low", busy, 0);
        chk(residual == LW'(len - taken), "R4 residual", residual, len - taken);
        chk(leftover == 2'(cnt), "R6 leftover", leftover, cnt);
        chk(hold_hi == w[31:16], "R6 hold_hi", hold_hi, w[31:16]);
        chk(hold_lo == w[15:0], "R6 hold_lo", hold_lo, w[15:0]);
        chk(exp_q.size() == 0, "R3 all words written", exp_q.size(), 0);
        if (half && first && cnt == 1)
            chk(leftover == 2'd1 && hold_lo[15:8] == w[15:8], "R7 offset single byte",
                {leftover, hold_lo}, {2'd1, w[15:0]});
        if (poke)
            chk(addr_err == 1'b0, "R9 start ignored while busy", addr_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk({busy, done, addr_err, half_mode, in_ready, wr_en} == 0, "R11 reset flags",
            {busy, done, addr_err, half_mode, in_ready, wr_en}, 0);
        chk({leftover, hold_hi, hold_lo, residual} == 0, "R11 reset state",
            {leftover, hold_hi, hold_lo, residual}, 0);
        xfer(16'h0100, 8, -1, 8'h10, 1'b0, 1'b0, -1);   // R3 two whole words
        xfer(16'h0204, 7, -1, 8'h20, 1'b0, 1'b0, -1);   // R6 three left
        xfer(16'h0208, 5, -1, 8'h30, 1'b1, 1'b0, -1);   // R6 one left, gaps
        xfer(16'h020C, 6, -1, 8'h40, 1'b1, 1'b0, -1);   // R6 two left
        xfer(16'h0302, 7, -1, 8'h50, 1'b0, 1'b0, -1);   // R2 offset start
        xfer(16'h0402, 1, -1, 8'h60, 1'b0, 1'b0, -1);   // R7
        xfer(16'h0501, 4, -1, 8'h70, 1'b0, 1'b0, -1);   // R1
        xfer(16'h0600, 20, 5, 8'h80, 1'b0, 1'b0, -1);   // R5 early end
        xfer(16'h0700, 0, -1, 8'h90, 1'b0, 1'b0, -1);   // R10
        xfer(16'h0800, 10, -1, 8'hA0, 1'b0, 1'b1, -1);  // R9
        xfer(16'h0902, 10, -1, 8'hB0, 1'b0, 1'b0, 3);   // R8 clear mid-transfer
        xfer(16'h1000, 255, -1, 8'hC0, 1'b1, 1'b0, -1); // R4 full length
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule